// File: doc/BRIEF.md
# Snapshot Timekeeping Register File

This block keeps calendar time in free-running BCD counters (seconds, minutes, 24-hour hours, weekday, date, month, two-digit year). The host never reads those counters directly. It sees a bank of eight byte-wide holding registers in an eight-byte window at the top of an 11-bit address space: one control byte and seven time bytes. A one-second strobe advances the counters.

While neither halt bit in the control byte is set, the holding bank copies the counters every clock, so reads track the time. Setting the read-hold bit freezes the bank at the time current when the halt was written, and the counters keep running. Setting the set-time bit also freezes the bank so the host can write a new time. Clearing that bit transfers all seven holding bytes into the counters at once.

Top module: `rtc_snap_top`

## Requirements
- R1: The counters advance by exactly one second on each clock cycle where `tick_i` is 1 and stay unchanged on every other cycle. This holds whether or not the holding bank is frozen, except in a load cycle (R5).
- R2: While control bits 7 and 6 are both 0, each time byte reads the counter value from the previous clock cycle. Values written to time bytes earlier are replaced.
- R3: Writing a control byte with bit 6 (read-hold) or bit 7 (set-time) set freezes the time bytes at the counter values of the cycle in which that write was presented. They stay frozen while either bit remains 1.
- R4: While frozen, a write to a time byte stores the written value. While not frozen, such a write is dropped and the byte keeps following the counters.
- R5: A control write with bit 7 = 0, presented while bit 7 is 1, loads all seven counters from the holding bytes in that single cycle. A tick in the same cycle is ignored.
- R6: The register map is 0x7F8 control, 0x7F9 seconds, 0x7FA minutes, 0x7FB hours, 0x7FC weekday, 0x7FD date, 0x7FE month and 0x7FF year. Reads are combinational from `addr_i`. Any address outside 0x7F8..0x7FF reads 0x00.
- R7: Time bytes store only their valid field bits: masks 0x7F, 0x7F, 0x3F, 0x07, 0x3F, 0x1F and 0xFF for seconds through year. Unused bits read 0.
- R8: Seconds and minutes roll from 0x59 to 0x00 and carry on. Hours roll from 0x23 to 0x00 and carry into both weekday and date.
- R9: Weekday counts 1 to 7 and wraps from 7 to 1.
- R10: Date wraps to 0x01 after the last day of the month: 31, 30, or 28 for February (29 when the year is divisible by four). Month 0x12 wraps to 0x01 and carries into the year, and year 0x99 wraps to 0x00.
- R11: Control bits 5..0 are stored and read back unchanged and have no effect on counting or freezing.
- R12: After reset, the counters and time bytes hold 00:00:00, weekday 01, date 01, month 01, year 00, and control reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| we_i | input | 1 | Byte write enable |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |

## Verification
A counter that drifts shows at the ports one cycle later as a wrong time byte whenever the bank is tracking. A wrong count made while frozen stays hidden until the halt is released, and then appears in the next cycle. A bank that fails to freeze, or a load that misses a field, shows as a changed or stale byte on the very next read of that address. The bench therefore reads a rotating address on every cycle, and it places month-end, leap-year and century-of-years rollovers straight after a load so that a carry error shows within three cycles.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

  typedef logic [7:0] byte_t;

  localparam int NUM_FIELDS = 7;
  localparam int IDX_W      = 3;

  function automatic byte_t bcd_inc(input byte_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // tens digit parity picks which units digits make a multiple of four
  function automatic logic is_leap(input byte_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic byte_t field_mask(input int k);
    case (k)
      0, 1:    return 8'h7F;
      2, 4:    return 8'h3F;
      3:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic byte_t field_min(input int k);
    return (k >= 3 && k <= 5) ? 8'h01 : 8'h00;
  endfunction

  function automatic byte_t field_max(input int k);
    case (k)
      0, 1:    return 8'h59;
      2:       return 8'h23;
      3:       return 8'h07;
      5:       return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bcd_ctr.sv
module rtc_bcd_ctr
  import rtc_snap_pkg::*;
#(
  parameter byte_t MIN_VAL = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  inc_i,
  input  logic  ld_i,
  input  byte_t ld_val_i,
  input  byte_t max_i,
  output byte_t val_o,
  output logic  at_max_o
);

  byte_t val_q, val_d;
  logic  en;

  assign en       = ld_i | inc_i;
  assign at_max_o = (val_q == max_i);
  assign val_o    = val_q;

  always_comb begin
    val_d = val_q;
    if (ld_i)       val_d = ld_val_i;
    else if (inc_i) val_d = at_max_o ? MIN_VAL : bcd_inc(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= MIN_VAL;
    else if (en) val_q <= val_d;
  end

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_snap_pkg::*;
(
  input  byte_t month_i,
  input  byte_t year_i,
  output byte_t last_o
);

  always_comb begin
    case (month_i)
      8'h02:                      last_o = is_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end

endmodule

// File: rtl/rtc_hold_bank.sv
module rtc_hold_bank
  import rtc_snap_pkg::*;
#(
  parameter int          ADDR_W = 11,
  parameter logic [10:0] BASE   = 11'h7F8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  byte_t                        wdata_i,
  input  logic [NUM_FIELDS-1:0][7:0]   cnt_i,
  output logic [NUM_FIELDS-1:0][7:0]   hold_o,
  output byte_t                        ctl_o,
  output logic                         load_o,
  output byte_t                        rdata_o
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

  logic [NUM_FIELDS-1:0][7:0] hold_q, hold_d;
  byte_t                      ctl_q, ctl_d;
  logic                       hit, halted, ctl_wr, hold_en;
  logic [IDX_W-1:0]           idx;

  assign hit     = (addr_i[ADDR_W-1:IDX_W] == BASE_A[ADDR_W-1:IDX_W]);
  assign idx     = addr_i[IDX_W-1:0];
  assign halted  = ctl_q[7] | ctl_q[6];
  assign ctl_wr  = we_i & hit & (idx == '0);
  assign load_o  = ctl_wr & ctl_q[7] & ~wdata_i[7];
  assign hold_en = ~halted | (we_i & hit);

  always_comb begin
    ctl_d  = ctl_wr ? wdata_i : ctl_q;
    hold_d = hold_q;
    for (int k = 0; k < NUM_FIELDS; k++) begin
      if (!halted)
        hold_d[k] = cnt_i[k];
      else if (we_i && hit && (idx == IDX_W'(k + 1)))
        hold_d[k] = wdata_i & field_mask(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= 8'h00;
    else if (ctl_wr) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_FIELDS; k++) hold_q[k] <= field_min(k);
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_comb begin
    if (!hit)            rdata_o = 8'h00;
    else if (idx == '0)  rdata_o = ctl_q;
    else                 rdata_o = hold_q[idx - IDX_W'(1)];
  end

  assign hold_o = hold_q;
  assign ctl_o  = ctl_q;

endmodule

// File: rtl/rtc_snap_top.sv
module rtc_snap_top
  import rtc_snap_pkg::*;
#(
  parameter int          ADDR_W = 11,
  parameter logic [10:0] BASE   = 11'h7F8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  logic [1:0]                 rst_sync_q;
  logic                       rst_n_sync;
  logic [NUM_FIELDS-1:0][7:0] cnt_w, hold_w, max_w;
  logic [NUM_FIELDS-1:0]      at_max, inc;
  byte_t                      ctl_w, date_last;
  logic                       load_w, adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  rtc_hold_bank #(.ADDR_W(ADDR_W), .BASE(BASE)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt_i   (cnt_w),
    .hold_o  (hold_w),
    .ctl_o   (ctl_w),
    .load_o  (load_w),
    .rdata_o (rdata_o)
  );

  rtc_month_len u_mlen (
    .month_i (cnt_w[5]),
    .year_i  (cnt_w[6]),
    .last_o  (date_last)
  );

  // carry chain: sec -> min -> hour -> (weekday, date) -> month -> year
  assign adv = tick_i & ~load_w;
  always_comb begin
    inc[0] = adv;
    inc[1] = inc[0] & at_max[0];
    inc[2] = inc[1] & at_max[1];
    inc[3] = inc[2] & at_max[2];
    inc[4] = inc[3];
    inc[5] = inc[4] & at_max[4];
    inc[6] = inc[5] & at_max[5];
  end

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    if (k == 4) begin : g_var
      assign max_w[k] = date_last;
    end else begin : g_fix
      assign max_w[k] = field_max(k);
    end
    rtc_bcd_ctr #(.MIN_VAL(field_min(k))) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .inc_i    (inc[k]),
      .ld_i     (load_w),
      .ld_val_i (hold_w[k]),
      .max_i    (max_w[k]),
      .val_o    (cnt_w[k]),
      .at_max_o (at_max[k])
    );
  end

endmodule

// File: rtl/rtc_snap_chk.sv
module rtc_snap_chk
  import rtc_snap_pkg::*;
#(
  parameter int          ADDR_W = 11,
  parameter logic [10:0] BASE   = 11'h7F8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick_i,
  input logic                       we_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [7:0]                 rdata_o,
  input logic [7:0]                 ctl,
  input logic [NUM_FIELDS-1:0][7:0] hold,
  input logic [NUM_FIELDS-1:0][7:0] cnt,
  input logic                       load
);

  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(BASE);

  logic in_win, frozen, time_wr;
  assign in_win  = (addr_i[ADDR_W-1:3] == WIN[ADDR_W-1:3]);
  assign frozen  = ctl[7] | ctl[6];
  assign time_wr = we_i & in_win & (addr_i[2:0] != 3'd0);

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load) |=> $stable(cnt)); // R1
  AST_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !frozen |=> (hold == $past(cnt))); // R2
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !time_wr) |=> $stable(hold)); // R3
  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(hold))); // R5
  AST_OUT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (rdata_o == 8'h00)); // R6
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load && cnt[0] == 8'h59) |=> (cnt[0] == 8'h00)); // R8
  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load && cnt[0] == 8'h59 && cnt[1] == 8'h59 && cnt[2] == 8'h23
     && cnt[3] == 8'h07) |=> (cnt[3] == 8'h01)); // R9

endmodule

bind rtc_snap_top rtc_snap_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .tick_i  (tick_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .ctl     (ctl_w),
  .hold    (hold_w),
  .cnt     (cnt_w),
  .load    (load_w)
);

// File: tb/rtc_snap_top_tb_top.sv
`timescale 1ns/1ps
module rtc_snap_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        we_i = 1'b0;
  logic [10:0] addr_i = 11'h7F8;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  rdata_o;

  int total = 0;
  int bad = 0;
  bit live = 0;
  bit done = 0;
  int scan = 0;

  always #4 clk = ~clk;

  rtc_snap_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  // behavioural reference: binary time, byte holding bank
  int m_t[7];
  int m_hold[7];
  int m_ctl;

  function automatic int to_bcd(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int from_bcd(int b); return (b >> 4) * 10 + (b & 15); endfunction
  function automatic int mask_of(int k);
    int m[7] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
    return m[k];
  endfunction
  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic m_reset();
    m_t = '{0, 0, 0, 1, 1, 1, 0};
    for (int k = 0; k < 7; k++) m_hold[k] = to_bcd(m_t[k]);
    m_ctl = 0;
  endtask

  task automatic m_advance();
    m_t[0]++;
    if (m_t[0] < 60) return;
    m_t[0] = 0; m_t[1]++;
    if (m_t[1] < 60) return;
    m_t[1] = 0; m_t[2]++;
    if (m_t[2] < 24) return;
    m_t[2] = 0;
    m_t[3] = (m_t[3] == 7) ? 1 : m_t[3] + 1;
    m_t[4]++;
    if (m_t[4] <= mdays(m_t[5], m_t[6])) return;
    m_t[4] = 1; m_t[5]++;
    if (m_t[5] <= 12) return;
    m_t[5] = 1; m_t[6] = (m_t[6] + 1) % 100;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      int  old_hold[7];
      bit  hit, halted, ld;
      int  idx;
      hit    = (addr_i[10:3] == 8'hFF);
      idx    = addr_i[2:0];
      halted = m_ctl[6] || m_ctl[7];
      ld     = we_i && hit && idx == 0 && m_ctl[7] && !wdata_i[7];
      old_hold = m_hold;
      for (int k = 0; k < 7; k++) begin
        if (!halted) m_hold[k] = to_bcd(m_t[k]);
        else if (we_i && hit && idx == k + 1) m_hold[k] = wdata_i & mask_of(k);
      end
      if (we_i && hit && idx == 0) m_ctl = wdata_i;
      if (ld) for (int k = 0; k < 7; k++) m_t[k] = from_bcd(old_hold[k]);
      else if (tick_i) m_advance();
    end
  end

  function automatic int m_read(logic [10:0] a);
    if (a[10:3] != 8'hFF) return 0;
    if (a[2:0] == 0) return m_ctl;
    return m_hold[a[2:0] - 1];
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%03h actual=%02h expected=%02h", tag, addr_i, act, exp);
    end
  endtask

  // per-cycle comparison against the model (register map and readback, R6)
  always @(posedge clk) begin
    #3;
    if (live) check(rdata_o, 8'(m_read(addr_i)), "R6");
  end

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      we_i = 0; tick_i = tk;
      addr_i = (scan % 9 == 8) ? 11'h1F3 : 11'h7F8 + 11'(scan % 9);
      scan++;
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d, input bit tk);
    @(posedge clk); #1;
    we_i = 1; tick_i = tk; addr_i = a; wdata_i = d;
  endtask

  task automatic rd(input logic [10:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    we_i = 0; tick_i = 0; addr_i = a;
    #2 check(rdata_o, exp, tag);
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, wd, dt, mo, y);
    wr(11'h7F8, 8'h80, 0);
    wr(11'h7F9, s, 0);  wr(11'h7FA, mi, 0); wr(11'h7FB, h, 0);
    wr(11'h7FC, wd, 0); wr(11'h7FD, dt, 0); wr(11'h7FE, mo, 0);
    wr(11'h7FF, y, 0);
    wr(11'h7F8, 8'h00, 1);
    idle(2, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    live = 1;
    // R12 reset state
    rd(11'h7F9, 8'h00, "R12"); rd(11'h7FC, 8'h01, "R12");
    rd(11'h7FD, 8'h01, "R12"); rd(11'h7FE, 8'h01, "R12");
    rd(11'h7F8, 8'h00, "R12");
    rd(11'h3F9, 8'h00, "R6");
    // R1 counting on ticks only
    idle(5, 1); idle(2, 0);
    rd(11'h7F9, 8'h05, "R1");
    idle(4, 0);
    rd(11'h7F9, 8'h05, "R1");
    // R11 calibration bits inert
    wr(11'h7F8, 8'h2A, 0);
    rd(11'h7F8, 8'h2A, "R11");
    idle(3, 1); idle(2, 0);
    rd(11'h7F9, 8'h08, "R11");
    // R3 read-hold freezes at halt moment
    wr(11'h7F8, 8'h40, 0);
    idle(10, 1); idle(2, 0);
    rd(11'h7F9, 8'h08, "R3");
    // R4 writes stored while frozen, R7 masking
    wr(11'h7FA, 8'h33, 0);
    rd(11'h7FA, 8'h33, "R4");
    wr(11'h7F9, 8'hFF, 0);
    rd(11'h7F9, 8'h7F, "R7");
    wr(11'h7FC, 8'hFD, 0);
    rd(11'h7FC, 8'h05, "R7");
    // R2 release: bank returns to counters (no load without set-time bit)
    wr(11'h7F8, 8'h00, 0);
    idle(2, 0);
    rd(11'h7F9, 8'h18, "R2");
    rd(11'h7FA, 8'h00, "R2");
    // R4 write dropped while tracking
    wr(11'h7FA, 8'h44, 0);
    rd(11'h7FA, 8'h00, "R4");
    // R5 load ignores tick in load cycle; leap February
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h04);
    rd(11'h7F9, 8'h59, "R5"); rd(11'h7FB, 8'h23, "R5");
    rd(11'h7FD, 8'h28, "R5");
    idle(1, 1); idle(2, 0);
    rd(11'h7F9, 8'h00, "R8"); rd(11'h7FA, 8'h00, "R8");
    rd(11'h7FB, 8'h00, "R8"); rd(11'h7FC, 8'h01, "R9");
    rd(11'h7FD, 8'h29, "R10"); rd(11'h7FE, 8'h02, "R10");
    // R10 non-leap February
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h03);
    idle(1, 1); idle(2, 0);
    rd(11'h7FD, 8'h01, "R10"); rd(11'h7FE, 8'h03, "R10");
    rd(11'h7FC, 8'h03, "R9");
    // R10 thirty-day month
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h21);
    idle(1, 1); idle(2, 0);
    rd(11'h7FD, 8'h01, "R10"); rd(11'h7FE, 8'h05, "R10");
    // R10 year end and year wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99);
    idle(1, 1); idle(2, 0);
    rd(11'h7FD, 8'h01, "R10"); rd(11'h7FE, 8'h01, "R10");
    rd(11'h7FF, 8'h00, "R10"); rd(11'h7FC, 8'h04, "R9");
    // R8 minute carry, R1 counting continues while frozen
    set_time(8'h58, 8'h09, 8'h13, 8'h05, 8'h15, 8'h06, 8'h50);
    wr(11'h7F8, 8'h40, 0);
    idle(3, 1);
    wr(11'h7F8, 8'h00, 0);
    idle(2, 0);
    rd(11'h7F9, 8'h01, "R1"); rd(11'h7FA, 8'h10, "R8");
    // long free run compared each cycle
    idle(4000, 1);
    idle(2, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule